// File: doc/BRIEF.md
# Consecutive Out-of-Limit Alert Filter

This block sits between the limit comparators of a temperature monitor and its shared interrupt line. Each completed conversion arrives as a single-cycle strobe with three flags: local channel out of limit, remote channel out of limit, and remote sensor open-circuit. The block counts back-to-back faulty conversions and asserts an active-low alert only once the run reaches a programmable length. Any clean conversion breaks the run.

The run length is held in an 8-bit configuration register. Bits 3:1 carry a thermometer code for the run length. Bit 7 is an unrelated enable for the bus inactivity timeout, and the block only passes it on to the bus interface. The alert pin is modelled for open-drain use: `alert_n` is the level the pin pulls to, and `alert_oe` is the pull-down enable. Several devices can therefore share one wired line.

A three-state machine does the counting. Its states are CLEAR (no faulty run), RUN (a run has started but is shorter than required) and ALERT (the run has reached the required length). It takes these transitions:
- CLEAR to RUN, or RUN to RUN, on a faulty strobe that leaves the run below the required length.
- CLEAR to ALERT, or RUN to ALERT, on a faulty strobe that brings the run to the required length.
- ALERT to ALERT on a further faulty strobe.
- Any state to CLEAR on a clean strobe.

Top module: `consec_alert_filter`

## Requirements
- R1: After reset the register reads 0x01, `bus_timeout_en` is 0, `alert_n` is 1 and `alert_oe` is 0.
- R2: Bits 3:1 of the register give the run length for the listed codes: 000 needs 1 faulty conversion, 001 needs 2, 011 needs 3 and 111 needs 4.
- R3: Bits 3:1 values outside the listed codes take the run length of the closest listed code below them: 010 gives 2, and 100, 101 and 110 give 3.
- R4: Bit 0 and bits 6:4 of the register have no effect on the run length.
- R5: A write stores `cfg_wdata` in the register one cycle later, readable on `cfg_q`. Bit 7 of the register drives `bus_timeout_en`.
- R6: A strobed conversion is faulty when `local_oor`, `remote_oor` or `remote_open` is 1. The open-circuit flag alone is enough.
- R7: A strobed conversion with all three flags at 0 clears the run. It deasserts the alert in the cycle after the strobe.
- R8: The alert asserts in the cycle after the strobe that completes the required run. The run count saturates, so the alert stays asserted while faulty conversions continue.
- R9: Flags sampled without `meas_valid` have no effect on the alert.
- R10: While asserted, the alert shows `alert_n`=0 and `alert_oe`=1. While deasserted, it shows `alert_n`=1 and `alert_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 8 | Configuration write data |
| meas_valid | input | 1 | One-cycle strobe per completed conversion |
| local_oor | input | 1 | Local channel out of limit |
| remote_oor | input | 1 | Remote channel out of limit |
| remote_open | input | 1 | Remote sensor open-circuit |
| cfg_q | output | 8 | Configuration register contents |
| bus_timeout_en | output | 1 | Bus inactivity timeout enable (register bit 7) |
| alert_n | output | 1 | Alert pin level, active low |
| alert_oe | output | 1 | Open-drain pull-down enable |

## Verification
The bench sweeps all eight run-length codes and fills the don't-care bits with changing values. For each code it drives runs longer than four conversions, cycling through the three fault flags. A decoder that read the code as a plain binary count, or used bit 0, would assert the alert on the wrong strobe. A counter that wrapped instead of saturating would drop the alert during a long run. Interrupted runs check that a single clean conversion restarts the count from zero, rather than resuming it. Idle cycles with fault flags held high, but no strobe, catch a design that samples flags outside conversions.

// File: rtl/alert_pkg.sv
package alert_pkg;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned CODE_LSB = 1;
    localparam int unsigned CODE_W   = 3;
    localparam int unsigned TO_BIT   = 7;
    localparam int unsigned MAX_RUN  = CODE_W + 1;
    localparam int unsigned CNT_W    = $clog2(MAX_RUN + 1);
    localparam logic [REG_W-1:0] REG_RESET = 8'h01;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_RUN   = 2'd1,
        ST_ALERT = 2'd2
    } run_state_t;
endpackage

// File: rtl/alert_cfg_reg.sv
module alert_cfg_reg
    import alert_pkg::*;
#(
    parameter int unsigned W = REG_W,
    parameter logic [W-1:0] RESET_VAL = REG_RESET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (we) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/alert_run_decode.sv
module alert_run_decode
    import alert_pkg::*;
#(
    parameter int unsigned CW = CODE_W,
    localparam int unsigned NW = $clog2(CW + 2)
) (
    input  logic [CW-1:0] code,
    output logic [NW-1:0] need
);
    // Largest k with (2^k - 1) <= code gives a run length of k + 1.
    always_comb begin
        need = NW'(1);
        for (int k = 1; k <= CW; k++) begin
            if ({1'b0, code} >= ((CW+1)'(1) << k) - (CW+1)'(1)) begin
                need = NW'(k + 1);
            end
        end
    end
endmodule

// File: rtl/alert_run_fsm.sv
module alert_run_fsm
    import alert_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          faulty,
    input  logic [CW-1:0] need,
    output logic          alert
);
    run_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        cnt_inc = (cnt_q >= need) ? need : cnt_q + CW'(1);
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (strobe) begin
            unique case (state_q)
                ST_CLEAR, ST_RUN, ST_ALERT: begin
                    if (!faulty) begin
                        state_d = ST_CLEAR;
                        cnt_d   = '0;
                    end else begin
                        cnt_d   = cnt_inc;
                        state_d = (cnt_inc >= need) ? ST_ALERT : ST_RUN;
                    end
                end
                default: begin
                    state_d = ST_CLEAR;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        alert = (state_q == ST_ALERT);
    end
endmodule

// File: rtl/consec_alert_filter.sv
module consec_alert_filter
    import alert_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             meas_valid,
    input  logic             local_oor,
    input  logic             remote_oor,
    input  logic             remote_open,
    output logic [REG_W-1:0] cfg_q,
    output logic             bus_timeout_en,
    output logic             alert_n,
    output logic             alert_oe
);
    logic [CNT_W-1:0] need;
    logic             faulty;
    logic             alert;

    alert_cfg_reg #(.W(REG_W), .RESET_VAL(REG_RESET)) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    alert_run_decode #(.CW(CODE_W)) dec_i (
        .code (cfg_q[CODE_LSB +: CODE_W]),
        .need (need)
    );

    always_comb begin
        faulty = local_oor | remote_oor | remote_open;
    end

    alert_run_fsm #(.CW(CNT_W)) fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (meas_valid),
        .faulty (faulty),
        .need   (need),
        .alert  (alert)
    );

    always_comb begin
        bus_timeout_en = cfg_q[TO_BIT];
        alert_n        = ~alert;
        alert_oe       = alert;
    end
endmodule

// File: rtl/alert_filter_chk.sv
module alert_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic       meas_valid,
    input logic       local_oor,
    input logic       remote_oor,
    input logic       remote_open,
    input logic [7:0] cfg_q,
    input logic       bus_timeout_en,
    input logic       alert_n,
    input logic       alert_oe
);
    logic any_flag;
    assign any_flag = local_oor | remote_oor | remote_open;

    a_r5_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == $past(cfg_wdata)) && (bus_timeout_en == $past(cfg_wdata[7])));

    a_r2_single_run: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && any_flag && cfg_q[3:1] == 3'b000) |=> alert_oe);

    a_r6_open_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && remote_open && cfg_q[3:1] == 3'b000) |=> !alert_n);

    a_r7_clean_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && !any_flag) |=> !alert_oe);

    a_r8_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_oe && meas_valid && any_flag) |=> alert_oe);

    a_r9_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |=> $stable(alert_oe));

    a_r10_pin_pair: assert property (@(posedge clk) disable iff (!rst_n)
        alert_n != alert_oe);
endmodule

bind consec_alert_filter alert_filter_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_we         (cfg_we),
    .cfg_wdata      (cfg_wdata),
    .meas_valid     (meas_valid),
    .local_oor      (local_oor),
    .remote_oor     (remote_oor),
    .remote_open    (remote_open),
    .cfg_q          (cfg_q),
    .bus_timeout_en (bus_timeout_en),
    .alert_n        (alert_n),
    .alert_oe       (alert_oe)
);

// File: tb/consec_alert_filter_tb.sv
module consec_alert_filter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       meas_valid = 1'b0;
    logic       local_oor = 1'b0;
    logic       remote_oor = 1'b0;
    logic       remote_open = 1'b0;
    logic [7:0] cfg_q;
    logic       bus_timeout_en;
    logic       alert_n;
    logic       alert_oe;

    int total = 0;
    int bad = 0;
    int m_cnt = 0;
    int m_need = 1;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    consec_alert_filter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .meas_valid(meas_valid), .local_oor(local_oor), .remote_oor(remote_oor),
        .remote_open(remote_open), .cfg_q(cfg_q), .bus_timeout_en(bus_timeout_en),
        .alert_n(alert_n), .alert_oe(alert_oe)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int need_of(input int code);
        if (code == 7) return 4;
        if (code >= 3) return 3;
        if (code >= 1) return 2;
        return 1;
    endfunction

    function automatic string code_tag(input int code);
        if (code == 0 || code == 1 || code == 3 || code == 7) return "R2";
        return "R3";
    endfunction

    task automatic check_alert(input string tag);
        int exp_on;
        exp_on = (m_cnt >= m_need) ? 1 : 0;
        check({tag, " R10 alert_oe"}, int'(alert_oe), exp_on);
        check({tag, " R10 alert_n"}, int'(alert_n), 1 - exp_on);
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        m_need = need_of(int'(v[3:1]));
        check("R5 readback", int'(cfg_q), int'(v));
        check("R5 timeout bit", int'(bus_timeout_en), int'(v[7]));
    endtask

    task automatic meas(input logic l, input logic r, input logic o);
        @(negedge clk);
        meas_valid = 1'b1; local_oor = l; remote_oor = r; remote_open = o;
        @(negedge clk);
        meas_valid = 1'b0; local_oor = 1'b0; remote_oor = 1'b0; remote_open = 1'b0;
        if (l | r | o) m_cnt = (m_cnt + 1 > m_need) ? m_need : m_cnt + 1;
        else m_cnt = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset cfg", int'(cfg_q), 1);
        check("R1 reset timeout", int'(bus_timeout_en), 0);
        check("R1 reset alert_n", int'(alert_n), 1);
        check("R1 reset alert_oe", int'(alert_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Default run length of one, open-circuit only (R6).
        meas(1'b0, 1'b0, 1'b1);
        check_alert("R6 open-only default");
        meas(1'b0, 1'b0, 1'b0);
        check_alert("R7 clean clears");

        for (int c = 0; c < 8; c++) begin
            for (int u = 0; u < 4; u++) begin
                logic [7:0] v;
                v = {u[0], 3'(u * 3 + c), 3'(c), u[1]};
                write_cfg(v);
                meas(1'b0, 1'b0, 1'b0);
                check_alert("R7 start clean");
                for (int k = 1; k <= 6; k++) begin
                    meas(k % 3 == 0, k % 3 == 1, k % 3 == 2);
                    check_alert({code_tag(c), " R4 R6 R8 run"});
                    check("R8 expected level", int'(alert_oe), (k >= need_of(c)) ? 1 : 0);
                end
                // Flags without strobe are ignored.
                @(negedge clk);
                local_oor = 1'b0; remote_oor = 1'b1; remote_open = 1'b1;
                repeat (3) @(negedge clk);
                local_oor = 1'b0; remote_oor = 1'b0; remote_open = 1'b0;
                check_alert("R9 no strobe");
                meas(1'b0, 1'b0, 1'b0);
                check_alert("R7 clean after run");
                // Interrupted run restarts from zero.
                meas(1'b1, 1'b0, 1'b0);
                meas(1'b0, 1'b0, 1'b0);
                meas(1'b0, 1'b1, 1'b0);
                check_alert({code_tag(c), " R7 restart"});
                check("R7 restart level", int'(alert_oe), (need_of(c) == 1) ? 1 : 0);
                meas(1'b0, 1'b0, 1'b0);
                // Faults seen while no alert and no strobe stay ignored.
                @(negedge clk);
                local_oor = 1'b1; remote_oor = 1'b1; remote_open = 1'b1;
                repeat (2) @(negedge clk);
                local_oor = 1'b0; remote_oor = 1'b0; remote_open = 1'b0;
                check("R9 idle flags", int'(alert_oe), 0);
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule